// File: doc/BRIEF.md
# Clock Mode and Power Controller

This block decides which oscillator drives a processor's bus clock and how the main clock is divided. It also controls when the CPU is halted. There are two oscillators: a fast main one and a slow sub one. Each appears at the block edge as an enable output and a stable-flag input. Software presents a control word with a one-cycle write strobe. The word holds a sub-oscillator enable, a main-oscillator-off request, a bus-source select, a stop request and an 8-bit division code. The block only acts on a request once the oscillator it needs reports stable. Requests that would leave the bus without a running clock are refused.

Four running modes are reported. High-speed and medium-speed take the bus clock from the main oscillator, undivided or divided. Low-speed takes it from the sub oscillator with the main one still running. Low-power takes it from the sub oscillator with the main one stopped. A WAIT-instruction pulse halts the CPU with the oscillators left running. A stop request turns every oscillator off. An interrupt pulse ends either state. After a stop, the block always comes back on the main clock divided by eight. The divided main clock is given as a one-cycle tick, and the bus clock as an enable plus a source select.

Top module: `clkmode_ctrl`

## Requirements
- R1: `clk_mode` reports the mode: 0 high-speed, 1 medium-speed, 2 low-speed, 3 low-power, 4 wait, 5 stop, 6 waking from stop.
- R2: The division code sets the period of `main_div_tick`. Code 0x12 gives a tick every cycle. Codes 0x02, 0x03, 0x04, 0x06, 0x08, 0x0A, 0x0C, 0x0E and 0x10 give a tick every N cycles, where N is the code's value.
- R3: After reset the state is as follows. Mode is medium-speed with code 0x08. The main oscillator is on and the sub oscillator is off. The bus runs from the main clock with its enable high. The error flag and the CPU halt are low.
- R4: The bus source moves to the sub clock only once the sub oscillator is enabled and `sub_stable` is high.
- R5: A move back to the main clock, or a new division code, takes effect only while the main oscillator is on and `main_stable` is high.
- R6: A main-off request stops the main oscillator only while the sub clock is the bus clock. On that entry the division code becomes 0x08.
- R7: A stop request drops both oscillator enables and the bus enable, and raises the CPU halt. An interrupt then restarts the main oscillator. Once `main_stable` is high, the block runs in medium-speed mode on the main clock with code 0x08.
- R8: Some writes are refused: main-off while the main clock is the current or requested bus source, and sub-off while the sub clock is the current or requested bus source. A refused write changes nothing else and sets `cfg_err`, which stays set until reset.
- R9: A WAIT pulse halts the CPU and drops the bus enable, with both oscillator enables unchanged. An interrupt returns to the mode that was active before.
- R10: After each change of bus source or division code, and on leaving the wake-up state, the bus enable is low for exactly one cycle.
- R11: An accepted write sets the sub oscillator enable to the value of its sub-enable field.
- R12: A division code outside the set in R2 is treated as 0x08.
- R13: Clearing the main-off request while in low-power mode turns the main oscillator back on. The bus stays on the sub clock until it is switched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe for the control word |
| cfg_sub_on | input | 1 | Sub oscillator enable request |
| cfg_main_off | input | 1 | Main oscillator off request |
| cfg_src_sub | input | 1 | Bus source request, 1 = sub clock |
| cfg_stop | input | 1 | Stop-mode request |
| cfg_div_code | input | 8 | Main clock division code |
| wait_pulse | input | 1 | WAIT-instruction pulse |
| irq_pulse | input | 1 | Interrupt wake pulse |
| main_stable | input | 1 | Main oscillator reports stable |
| sub_stable | input | 1 | Sub oscillator reports stable |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| bclk_en | output | 1 | Bus clock enable |
| bclk_sel_sub | output | 1 | Bus clock source, 1 = sub clock |
| main_div_tick | output | 1 | Divided main clock tick |
| cpu_halt | output | 1 | CPU halt |
| clk_mode | output | 3 | Current mode code |
| cfg_err | output | 1 | Sticky refused-write flag |

## Verification
The hardest state to reach is the return from low-power operation to the main clock. It needs a chain of steps, each gated on a different stable flag. The stimulus first brings up the sub oscillator, holding `sub_stable` low to show the switch waiting. It then raises the flag, stops the main clock and passes through a wait cycle. Finally it clears the main-off request with `main_stable` held low, which shows the main oscillator running while the bus stays on the sub clock. Raising the flag then completes the return. The stop-and-wake path reuses a division code other than 0x08, so that the tick period after wake-up shows the forced divide-by-eight.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  localparam int CODE_W = 8;
  localparam int CNT_W  = 5;

  localparam logic [CODE_W-1:0] CODE_DIV8  = 8'h08;
  localparam logic [CODE_W-1:0] CODE_NODIV = 8'h12;

  typedef enum logic [1:0] {
    P_RUN  = 2'd0,
    P_WAIT = 2'd1,
    P_STOP = 2'd2,
    P_WAKE = 2'd3
  } pwr_e;

  typedef enum logic [2:0] {
    M_HIGH = 3'd0,
    M_MED  = 3'd1,
    M_LOW  = 3'd2,
    M_LPD  = 3'd3,
    M_WAIT = 3'd4,
    M_STOP = 3'd5,
    M_WAKE = 3'd6
  } mode_e;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    case (c)
      8'h02, 8'h03, 8'h04, 8'h06, 8'h08,
      8'h0A, 8'h0C, 8'h0E, 8'h10, 8'h12: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] code_norm(input logic [CODE_W-1:0] c);
    return code_ok(c) ? c : CODE_DIV8;
  endfunction

  function automatic logic [CNT_W-1:0] code_divisor(input logic [CODE_W-1:0] c);
    return (c == CODE_NODIV) ? CNT_W'(1) : CNT_W'(c);
  endfunction

endpackage

// File: rtl/clkmode_div.sv
module clkmode_div
  import clkmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] divisor_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart_i || !en_i)
      cnt_d = '0;
    else if (cnt_q == '0)
      cnt_d = divisor_i - CNT_W'(1);
    else
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = en_i && (cnt_q == '0);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && en_i && !restart_i && divisor_i != CNT_W'(1)) |=> !tick_o); // R2

endmodule

// File: rtl/clkmode_gate.sv
module clkmode_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic change_i,
  output logic bclk_en_o
);

  logic gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= 1'b0;
    else        gap_q <= change_i;
  end

  assign bclk_en_o = run_i && !gap_q;

  AST_GAP_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    change_i |=> !bclk_en_o); // R10

endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
  import clkmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              sub_on_i,
  input  logic              main_off_i,
  input  logic              src_sub_i,
  input  logic              stop_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wait_i,
  input  logic              irq_i,
  input  logic              main_stable_i,
  input  logic              sub_stable_i,
  output logic              main_osc_en_o,
  output logic              sub_osc_en_o,
  output logic              src_sub_o,
  output logic              halt_o,
  output logic              run_o,
  output logic [CODE_W-1:0] code_o,
  output logic              gap_req_o,
  output logic              div_restart_o,
  output logic [2:0]        mode_o,
  output logic              err_o
);

  pwr_e              pwr_q, pwr_d;
  logic              src_q, src_d, pend_src_q, pend_src_d;
  logic              main_on_q, main_on_d, sub_on_q, sub_on_d;
  logic              pend_moff_q, pend_moff_d, err_q, err_d;
  logic [CODE_W-1:0] div_q, div_d, pend_div_q, pend_div_d;
  logic              legal, sw_ok, div_ok, moff_ok, mon_ok;
  mode_e             mode_c;

  always_comb begin
    legal   = !((main_off_i && (!src_sub_i || !src_q)) ||
                (!sub_on_i  && ( src_sub_i ||  src_q)));
    sw_ok   = (pend_src_q && !src_q && sub_on_q && sub_stable_i) ||
              (!pend_src_q && src_q && main_on_q && main_stable_i);
    div_ok  = (pend_div_q != div_q) && main_on_q && main_stable_i;
    moff_ok = pend_moff_q && main_on_q && src_q;
    mon_ok  = !pend_moff_q && !main_on_q;
  end

  always_comb begin
    pwr_d         = pwr_q;
    src_d         = src_q;
    pend_src_d    = pend_src_q;
    main_on_d     = main_on_q;
    sub_on_d      = sub_on_q;
    pend_moff_d   = pend_moff_q;
    div_d         = div_q;
    pend_div_d    = pend_div_q;
    err_d         = err_q;
    gap_req_o     = 1'b0;
    div_restart_o = 1'b0;
    case (pwr_q)
      P_RUN: begin
        if (wr_i) begin
          if (stop_i) begin
            pwr_d = P_STOP;
          end else if (legal) begin
            sub_on_d    = sub_on_i;
            pend_src_d  = src_sub_i;
            pend_moff_d = main_off_i;
            pend_div_d  = code_norm(code_i);
          end else begin
            err_d = 1'b1;
          end
        end else if (wait_i) begin
          pwr_d = P_WAIT;
        end else if (sw_ok) begin
          src_d     = pend_src_q;
          gap_req_o = 1'b1;
        end else if (div_ok) begin
          div_d         = pend_div_q;
          gap_req_o     = 1'b1;
          div_restart_o = 1'b1;
        end else if (moff_ok) begin
          main_on_d     = 1'b0;
          div_d         = CODE_DIV8;
          pend_div_d    = CODE_DIV8;
          div_restart_o = 1'b1;
        end else if (mon_ok) begin
          main_on_d = 1'b1;
        end
      end
      P_WAIT: begin
        if (irq_i) pwr_d = P_RUN;
      end
      P_STOP: begin
        if (irq_i) begin
          pwr_d       = P_WAKE;
          src_d       = 1'b0;
          pend_src_d  = 1'b0;
          main_on_d   = 1'b1;
          pend_moff_d = 1'b0;
          div_d       = CODE_DIV8;
          pend_div_d  = CODE_DIV8;
        end
      end
      default: begin
        if (main_stable_i) begin
          pwr_d         = P_RUN;
          gap_req_o     = 1'b1;
          div_restart_o = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q       <= P_RUN;
      src_q       <= 1'b0;
      pend_src_q  <= 1'b0;
      main_on_q   <= 1'b1;
      sub_on_q    <= 1'b0;
      pend_moff_q <= 1'b0;
      div_q       <= CODE_DIV8;
      pend_div_q  <= CODE_DIV8;
      err_q       <= 1'b0;
    end else begin
      pwr_q       <= pwr_d;
      src_q       <= src_d;
      pend_src_q  <= pend_src_d;
      main_on_q   <= main_on_d;
      sub_on_q    <= sub_on_d;
      pend_moff_q <= pend_moff_d;
      div_q       <= div_d;
      pend_div_q  <= pend_div_d;
      err_q       <= err_d;
    end
  end

  always_comb begin
    case (pwr_q)
      P_RUN:   mode_c = src_q ? (main_on_q ? M_LOW : M_LPD)
                              : ((div_q == CODE_NODIV) ? M_HIGH : M_MED);
      P_WAIT:  mode_c = M_WAIT;
      P_STOP:  mode_c = M_STOP;
      default: mode_c = M_WAKE;
    endcase
  end

  assign mode_o        = mode_c;
  assign main_osc_en_o = main_on_q && (pwr_q != P_STOP);
  assign sub_osc_en_o  = sub_on_q  && (pwr_q != P_STOP);
  assign halt_o        = (pwr_q != P_RUN);
  assign run_o         = (pwr_q == P_RUN);
  assign src_sub_o     = src_q;
  assign code_o        = div_q;
  assign err_o         = err_q;

  AST_SUB_SWITCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_q) |-> ($past(sub_stable_i) && $past(sub_on_q))); // R4
  AST_MAIN_SWITCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(src_q) && $past(pwr_q) == P_RUN) |-> $past(main_stable_i)); // R5
  AST_MAIN_OFF_FROM_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(main_on_q) && $past(pwr_q) == P_RUN) |-> (src_q && div_q == CODE_DIV8)); // R6
  AST_WAKE_FORCES_DIV8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q == P_WAKE && $past(pwr_q) == P_STOP) |-> (!src_q && main_on_q && div_q == CODE_DIV8)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R8
  AST_CODE_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok(div_q)); // R12

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sub_on,
  input  logic              cfg_main_off,
  input  logic              cfg_src_sub,
  input  logic              cfg_stop,
  input  logic [CODE_W-1:0] cfg_div_code,
  input  logic              wait_pulse,
  input  logic              irq_pulse,
  input  logic              main_stable,
  input  logic              sub_stable,
  output logic              main_osc_en,
  output logic              sub_osc_en,
  output logic              bclk_en,
  output logic              bclk_sel_sub,
  output logic              main_div_tick,
  output logic              cpu_halt,
  output logic [2:0]        clk_mode,
  output logic              cfg_err
);

  logic              run, gap_req, div_restart;
  logic [CODE_W-1:0] code;

  clkmode_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_i          (cfg_wr),
    .sub_on_i      (cfg_sub_on),
    .main_off_i    (cfg_main_off),
    .src_sub_i     (cfg_src_sub),
    .stop_i        (cfg_stop),
    .code_i        (cfg_div_code),
    .wait_i        (wait_pulse),
    .irq_i         (irq_pulse),
    .main_stable_i (main_stable),
    .sub_stable_i  (sub_stable),
    .main_osc_en_o (main_osc_en),
    .sub_osc_en_o  (sub_osc_en),
    .src_sub_o     (bclk_sel_sub),
    .halt_o        (cpu_halt),
    .run_o         (run),
    .code_o        (code),
    .gap_req_o     (gap_req),
    .div_restart_o (div_restart),
    .mode_o        (clk_mode),
    .err_o         (cfg_err)
  );

  clkmode_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .change_i  (gap_req),
    .bclk_en_o (bclk_en)
  );

  clkmode_div u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (main_osc_en),
    .restart_i (div_restart),
    .divisor_i (code_divisor(code)),
    .tick_o    (main_div_tick)
  );

endmodule

// File: tb/clkmode_ctrl_test.sv
module clkmode_ctrl_test;

  localparam int O_MODE = 0, O_BEN = 1, O_SEL = 2, O_HALT = 3;
  localparam int O_MEN = 4, O_SEN = 5, O_ERR = 6, O_TICKS = 7;

  typedef struct {
    int    idx;
    int    exp;
    int    got;
    string rq;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, cfg_sub_on, cfg_main_off, cfg_src_sub, cfg_stop;
  logic [7:0] cfg_div_code;
  logic       wait_pulse, irq_pulse, main_stable, sub_stable;
  logic       main_osc_en, sub_osc_en, bclk_en, bclk_sel_sub;
  logic       main_div_tick, cpu_halt, cfg_err;
  logic [2:0] clk_mode;

  item_t sb[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #2 clk = ~clk;

  clkmode_ctrl uut (
    .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_sub_on (cfg_sub_on),
    .cfg_main_off (cfg_main_off), .cfg_src_sub (cfg_src_sub), .cfg_stop (cfg_stop),
    .cfg_div_code (cfg_div_code), .wait_pulse (wait_pulse), .irq_pulse (irq_pulse),
    .main_stable (main_stable), .sub_stable (sub_stable), .main_osc_en (main_osc_en),
    .sub_osc_en (sub_osc_en), .bclk_en (bclk_en), .bclk_sel_sub (bclk_sel_sub),
    .main_div_tick (main_div_tick), .cpu_halt (cpu_halt), .clk_mode (clk_mode),
    .cfg_err (cfg_err)
  );

  function automatic int observe(input int idx);
    case (idx)
      O_MODE:  return int'(clk_mode);
      O_BEN:   return int'(bclk_en);
      O_SEL:   return int'(bclk_sel_sub);
      O_HALT:  return int'(cpu_halt);
      O_MEN:   return int'(main_osc_en);
      O_SEN:   return int'(sub_osc_en);
      default: return int'(cfg_err);
    endcase
  endfunction

  // monitor: compare every queued expectation against the outputs
  always @(negedge clk) begin
    item_t it;
    int    got;
    while (sb.size() > 0) begin
      it  = sb.pop_front();
      got = (it.idx == O_TICKS) ? it.got : observe(it.idx);
      n_cmp++;
      if (got != it.exp) begin
        n_bad++;
        $display("FAIL %s obs=%0d actual=%0d expected=%0d t=%0t", it.rq, it.idx, got, it.exp, $time);
      end
    end
  end

  task automatic expect_out(input int idx, input int val, input string rq);
    item_t it;
    it.idx = idx; it.exp = val; it.got = 0; it.rq = rq;
    sb.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic s_on, input logic m_off, input logic src,
                    input logic stp, input logic [7:0] code);
    @(negedge clk);
    cfg_sub_on = s_on; cfg_main_off = m_off; cfg_src_sub = src;
    cfg_stop = stp; cfg_div_code = code; cfg_wr = 1'b1;
    @(posedge clk);
    #1;
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_wait();
    @(negedge clk); wait_pulse = 1'b1;
    @(posedge clk); #1; wait_pulse = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_pulse = 1'b1;
    @(posedge clk); #1; irq_pulse = 1'b0;
  endtask

  task automatic count_ticks(input int n, input int exp, input string rq);
    item_t it;
    int c = 0;
    repeat (n) begin
      @(negedge clk);
      if (main_div_tick) c++;
    end
    it.idx = O_TICKS; it.exp = exp; it.got = c; it.rq = rq;
    sb.push_back(it);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sub_on = 1'b0; cfg_main_off = 1'b0;
    cfg_src_sub = 1'b0; cfg_stop = 1'b0; cfg_div_code = 8'h00;
    wait_pulse = 1'b0; irq_pulse = 1'b0; main_stable = 1'b1; sub_stable = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    // R3 reset state
    expect_out(O_MODE, 1, "R3"); expect_out(O_BEN, 1, "R3");
    expect_out(O_SEL, 0, "R3");  expect_out(O_HALT, 0, "R3");
    expect_out(O_MEN, 1, "R3");  expect_out(O_SEN, 0, "R3");
    expect_out(O_ERR, 0, "R3");
    step(2);
    count_ticks(32, 4, "R3");

    // R2 undivided main clock
    wr(0, 0, 0, 0, 8'h12);
    step(1);
    expect_out(O_MODE, 0, "R1"); expect_out(O_BEN, 0, "R10");
    step(1);
    expect_out(O_BEN, 1, "R10");
    count_ticks(16, 16, "R2");

    // R5 new division waits for main stable
    @(negedge clk); main_stable = 1'b0;
    wr(0, 0, 0, 0, 8'h03);
    step(3);
    expect_out(O_MODE, 0, "R5");
    @(negedge clk); main_stable = 1'b1;
    @(posedge clk); #1;
    expect_out(O_MODE, 1, "R5"); expect_out(O_BEN, 0, "R10");
    step(1);
    count_ticks(12, 4, "R2");

    // R12 unsupported code acts as divide-by-8
    wr(0, 0, 0, 0, 8'h05);
    step(2);
    count_ticks(24, 3, "R12");

    // R8 main-off while main is bus clock is refused
    wr(0, 1, 0, 0, 8'h05);
    expect_out(O_ERR, 1, "R8");
    step(2);
    expect_out(O_MEN, 1, "R8"); expect_out(O_MODE, 1, "R8");

    // R4 switch to sub waits for sub stable
    wr(1, 0, 1, 0, 8'h05);
    expect_out(O_SEN, 1, "R11");
    step(3);
    expect_out(O_SEL, 0, "R4"); expect_out(O_MODE, 1, "R4");
    @(negedge clk); sub_stable = 1'b1;
    @(posedge clk); #1;
    expect_out(O_SEL, 1, "R4"); expect_out(O_MODE, 2, "R1");
    expect_out(O_BEN, 0, "R10");
    step(1);
    expect_out(O_BEN, 1, "R10");

    // R8 sub-off while sub is bus clock is refused
    wr(0, 0, 1, 0, 8'h05);
    step(2);
    expect_out(O_SEN, 1, "R8"); expect_out(O_SEL, 1, "R8");
    expect_out(O_ERR, 1, "R8");

    // R6 main off from sub operation
    wr(1, 1, 1, 0, 8'h05);
    step(1);
    expect_out(O_MEN, 0, "R6"); expect_out(O_MODE, 3, "R6");
    expect_out(O_BEN, 1, "R6");

    // R9 wait and return
    pulse_wait();
    expect_out(O_HALT, 1, "R9"); expect_out(O_BEN, 0, "R9");
    expect_out(O_MODE, 4, "R9"); expect_out(O_SEN, 1, "R9");
    expect_out(O_MEN, 0, "R9");
    step(3);
    pulse_irq();
    expect_out(O_HALT, 0, "R9"); expect_out(O_MODE, 3, "R9");
    expect_out(O_BEN, 1, "R9");

    // R13 restart main from low-power, then R5 switch back
    @(negedge clk); main_stable = 1'b0;
    wr(1, 0, 0, 0, 8'h08);
    step(1);
    expect_out(O_MEN, 1, "R13"); expect_out(O_MODE, 2, "R13");
    expect_out(O_SEL, 1, "R13");
    step(2);
    expect_out(O_SEL, 1, "R5");
    @(negedge clk); main_stable = 1'b1;
    @(posedge clk); #1;
    expect_out(O_SEL, 0, "R5"); expect_out(O_MODE, 1, "R5");
    expect_out(O_BEN, 0, "R10");

    wr(1, 0, 0, 0, 8'h03);
    step(2);
    count_ticks(12, 4, "R2");

    // R7 stop and wake
    wr(1, 0, 0, 1, 8'h03);
    expect_out(O_MODE, 5, "R7"); expect_out(O_MEN, 0, "R7");
    expect_out(O_SEN, 0, "R7");  expect_out(O_HALT, 1, "R7");
    expect_out(O_BEN, 0, "R7");
    @(negedge clk); main_stable = 1'b0;
    step(2);
    pulse_irq();
    expect_out(O_MODE, 6, "R7"); expect_out(O_MEN, 1, "R7");
    expect_out(O_HALT, 1, "R7");
    step(2);
    expect_out(O_MODE, 6, "R7");
    @(negedge clk); main_stable = 1'b1;
    @(posedge clk); #1;
    expect_out(O_MODE, 1, "R7"); expect_out(O_HALT, 0, "R7");
    expect_out(O_BEN, 0, "R10"); expect_out(O_SEL, 0, "R7");
    step(1);
    expect_out(O_BEN, 1, "R10");
    count_ticks(32, 4, "R7");

    step(2);
    done = 1'b1;
    finish_run();
  end

endmodule